// File: doc/BRIEF.md
# Shift and Rotate Unit with Extend Bit

This block is the shift and rotate datapath of a 32-bit processor's integer unit. In one pass it performs arithmetic shifts, logical shifts, plain rotates and rotates that run through a separate extend bit. Each operation works at byte, word or long operand size. The operation select, size select, shift count, operand and current extend flag arrive on the block's inputs. One clock later the registered result appears together with five flags: carry, extend, zero, negative and overflow.

For byte and word sizes, only the low lane is processed. The bits above the lane leave the block exactly as they came in. The zero and negative flags look only at the selected lane. The extend bit has two roles. In the extended rotates it is a real stage of the rotating ring. In the plain rotates it is left alone. Counts from 0 to 63 are handled in a single cycle, so no sequencer is needed for long counts.

Top module: `shrot_unit`

## Requirements
- R1: Arithmetic right shift (operation code 1) fills vacated lane bits with the lane's sign bit. Carry takes the last bit shifted out. A count at or above the lane width gives a lane of all sign bits, with carry equal to the sign.
- R2: Logical shifts fill vacated bits with zeros. Left is operation code 2 and right is operation code 3. Carry takes the last bit shifted out. A count greater than the lane width gives a zero lane with carry 0.
- R3: Arithmetic left shift (operation code 0) produces the same lane as a logical left shift. Overflow is 1 exactly when the lane's top bit changes value at any single step of the shift. Every other operation code gives overflow 0.
- R4: Plain rotates use operation code 4 for left and code 5 for right. Only the lane bits circulate, so the effective count is the count modulo the lane width. Carry is the last bit rotated out: the result's bit 0 for left and the result's lane top bit for right. Extend output equals the extend input.
- R5: Extended rotates use operation code 6 for left and code 7 for right. They rotate the lane together with the extend bit as a ring one bit wider than the lane, with the extend bit directly above the lane's top bit. The effective count is the count modulo the lane width plus one. Carry and extend output both equal the extend bit that results.
- R6: A count of 0 returns the operand unchanged and passes the extend input through. Carry is 0, except for the extended rotates, where carry equals the extend input.
- R7: For the four shifts with a nonzero count, extend output equals carry output.
- R8: Size code 0 selects an 8-bit lane, code 1 a 16-bit lane, and codes 2 and 3 a 32-bit lane. Result bits above the lane equal the operand's bits there.
- R9: Zero is 1 when the result lane is all zeros. Negative is the result lane's top bit. Bits above the lane affect neither flag.
- R10: All outputs are registered. Inputs sampled at a rising clock edge show up on the outputs right after that edge. A synchronous active-high reset clears the result and all five flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (0..7, see R1 to R5) |
| size_i | input | 2 | Lane size code (see R8) |
| count_i | input | 6 | Shift or rotate count, 0 to 63 |
| operand_i | input | 32 | Operand |
| ext_i | input | 1 | Current extend flag |
| result_o | output | 32 | Result, upper bits passed through for narrow sizes |
| carry_o | output | 1 | Carry flag |
| ext_o | output | 1 | Extend flag |
| zero_o | output | 1 | Zero flag over the lane |
| neg_o | output | 1 | Negative flag over the lane |
| ovf_o | output | 1 | Overflow flag |

## Verification
The result and all five flags pass through exactly one register, so every one of them is due at the first rising edge after the stimulus is applied. The bench drives inputs on a falling edge and waits for the next rising edge. It samples on the falling edge that follows, half a period away from any update. One test drives new inputs and reads the outputs before the capturing edge, which confirms that nothing arrives early. The expected values come from a step-by-step model that moves one bit per count step, instead of the closed-form shifters used in the RTL.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    OP_ARITH_L = 3'd0,
    OP_ARITH_R = 3'd1,
    OP_LOGIC_L = 3'd2,
    OP_LOGIC_R = 3'd3,
    OP_ROT_L   = 3'd4,
    OP_ROT_R   = 3'd5,
    OP_XROT_L  = 3'd6,
    OP_XROT_R  = 3'd7
  } sr_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_LONG2 = 2'd3
  } sr_size_e;

  typedef struct packed {
    logic carry;
    logic ext;
    logic zero;
    logic neg;
    logic ovf;
  } sr_flags_t;

endpackage

// File: rtl/shrot_lane_sel.sv
module shrot_lane_sel #(
  parameter int DATA_W = 32,
  parameter int WID_W  = $clog2(DATA_W) + 1
) (
  input  logic [1:0]        size_i,
  output logic [WID_W-1:0]  width_o,
  output logic [DATA_W-1:0] mask_o
);
  import shrot_pkg::*;

  sr_size_e size;
  assign size = sr_size_e'(size_i);

  always_comb begin
    unique case (size)
      SZ_BYTE: width_o = WID_W'(DATA_W / 4);
      SZ_WORD: width_o = WID_W'(DATA_W / 2);
      default: width_o = WID_W'(DATA_W);
    endcase
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask_o[g] = (WID_W'(g) < width_o);
  end

endmodule

// File: rtl/shrot_shift_core.sv
module shrot_shift_core #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6,
  parameter int WID_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] lane_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              right_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int CW    = ((CNT_W > WID_W) ? CNT_W : WID_W) + 1;

  logic [CW-1:0]     cnt_e, wid_e;
  logic [IDX_W-1:0]  msb_idx, lidx, ridx;
  logic              sign, in_range, over;
  logic [DATA_W-1:0] shl, shr, fill, win;
  logic [CNT_W:0]    cnt_p1;
  logic              carry_l, carry_r, ovf_raw;

  assign cnt_e    = CW'(count_i);
  assign wid_e    = CW'(width_i);
  assign msb_idx  = IDX_W'(width_i - WID_W'(1));
  assign sign     = lane_i[msb_idx];
  assign in_range = (cnt_e != '0) && (cnt_e <= wid_e);
  assign over     = (cnt_e > wid_e);
  assign lidx     = IDX_W'(wid_e - cnt_e);
  assign ridx     = IDX_W'(cnt_e - CW'(1));

  // lane-confined shifted values
  assign shl  = (lane_i << count_i) & mask_i;
  assign shr  = lane_i >> count_i;
  assign fill = sign ? (mask_i & ~(mask_i >> count_i)) : '0;

  // bit shifted out last
  assign carry_l = in_range ? lane_i[lidx] : 1'b0;
  always_comb begin
    if (in_range)             carry_r = lane_i[ridx];
    else if (over && arith_i) carry_r = sign;
    else                      carry_r = 1'b0;
  end

  // top bits the sign position sweeps through during a left shift
  assign cnt_p1 = {1'b0, count_i} + (CNT_W+1)'(1);
  assign win    = mask_i & ~(mask_i >> cnt_p1);
  always_comb begin
    if (cnt_e >= wid_e) ovf_raw = |lane_i;
    else                ovf_raw = ((lane_i & win) != '0) && ((lane_i & win) != win);
  end

  assign res_o   = right_i ? (shr | (arith_i ? fill : '0)) : shl;
  assign carry_o = right_i ? carry_r : carry_l;
  assign ovf_o   = arith_i & ~right_i & ovf_raw;

endmodule

// File: rtl/shrot_rot_core.sv
module shrot_rot_core #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6,
  parameter int WID_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] lane_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              ext_i,
  input  logic              thru_i,
  input  logic              right_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              ext_o
);
  localparam int RING_W    = DATA_W + 1;
  localparam int IDX_W     = $clog2(DATA_W);
  localparam int XI_W      = $clog2(RING_W);
  localparam int AMT_W     = ((CNT_W > WID_W) ? CNT_W : WID_W) + 1;
  localparam int SUB_STEPS = (1 << CNT_W) / (DATA_W / 4) + 1;

  logic [AMT_W-1:0]    ring_len, rem, amt;
  logic [RING_W-1:0]   ring, ring_mask, rotated;
  logic [2*RING_W-1:0] tmp;
  logic                xbit, msb, lsb, plain_c;

  assign ring_len = AMT_W'(width_i) + AMT_W'(thru_i);

  // count modulo ring length, by bounded subtraction
  always_comb begin
    rem = AMT_W'(count_i);
    for (int k = 0; k < SUB_STEPS; k++) begin
      if (rem >= ring_len) rem = rem - ring_len;
    end
  end

  assign amt = (right_i && (rem != '0)) ? (ring_len - rem) : rem;

  assign ring      = {1'b0, lane_i} | (thru_i ? (RING_W'(ext_i) << width_i) : '0);
  assign ring_mask = {1'b0, mask_i} | (thru_i ? (RING_W'(1) << width_i) : '0);

  assign tmp     = {{RING_W{1'b0}}, ring} << amt;
  assign rotated = (tmp[RING_W-1:0] | RING_W'(tmp >> ring_len)) & ring_mask;

  assign xbit = rotated[XI_W'(width_i)];
  assign msb  = rotated[IDX_W'(width_i - WID_W'(1))];
  assign lsb  = rotated[0];

  assign plain_c = (count_i == '0) ? 1'b0 : (right_i ? msb : lsb);

  assign res_o   = rotated[DATA_W-1:0] & mask_i;
  assign carry_o = thru_i ? xbit : plain_c;
  assign ext_o   = thru_i ? xbit : ext_i;

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              ext_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              ext_o,
  output logic              zero_o,
  output logic              neg_o,
  output logic              ovf_o
);
  import shrot_pkg::*;

  localparam int WID_W = $clog2(DATA_W) + 1;
  localparam int IDX_W = $clog2(DATA_W);

  sr_op_e            op;
  logic              arith, right, rot, thru;
  logic [WID_W-1:0]  width;
  logic [DATA_W-1:0] mask, lane;
  logic [DATA_W-1:0] sh_res, rot_res, lane_res;
  logic              sh_c, sh_ovf, rot_c, rot_x;
  logic [DATA_W-1:0] res_d, res_q;
  sr_flags_t         flg_d, flg_q;

  assign op = sr_op_e'(op_i);

  always_comb begin
    arith = 1'b0;
    right = 1'b0;
    rot   = 1'b0;
    thru  = 1'b0;
    unique case (op)
      OP_ARITH_L: arith = 1'b1;
      OP_ARITH_R: begin arith = 1'b1; right = 1'b1; end
      OP_LOGIC_L: ;
      OP_LOGIC_R: right = 1'b1;
      OP_ROT_L:   rot = 1'b1;
      OP_ROT_R:   begin rot = 1'b1; right = 1'b1; end
      OP_XROT_L:  begin rot = 1'b1; thru = 1'b1; end
      OP_XROT_R:  begin rot = 1'b1; thru = 1'b1; right = 1'b1; end
    endcase
  end

  shrot_lane_sel #(.DATA_W(DATA_W), .WID_W(WID_W)) u_lane (
    .size_i  (size_i),
    .width_o (width),
    .mask_o  (mask)
  );

  assign lane = operand_i & mask;

  shrot_shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W), .WID_W(WID_W)) u_shift (
    .lane_i  (lane),
    .mask_i  (mask),
    .width_i (width),
    .count_i (count_i),
    .right_i (right),
    .arith_i (arith),
    .res_o   (sh_res),
    .carry_o (sh_c),
    .ovf_o   (sh_ovf)
  );

  shrot_rot_core #(.DATA_W(DATA_W), .CNT_W(CNT_W), .WID_W(WID_W)) u_rot (
    .lane_i  (lane),
    .mask_i  (mask),
    .width_i (width),
    .count_i (count_i),
    .ext_i   (ext_i),
    .thru_i  (thru),
    .right_i (right),
    .res_o   (rot_res),
    .carry_o (rot_c),
    .ext_o   (rot_x)
  );

  assign lane_res = (rot ? rot_res : sh_res) & mask;
  assign res_d    = (operand_i & ~mask) | lane_res;

  always_comb begin
    flg_d.zero = (lane_res == '0);
    flg_d.neg  = lane_res[IDX_W'(width - WID_W'(1))];
    if (rot) begin
      flg_d.carry = rot_c;
      flg_d.ext   = rot_x;
      flg_d.ovf   = 1'b0;
    end else begin
      flg_d.carry = sh_c;
      flg_d.ext   = (count_i == '0) ? ext_i : sh_c;
      flg_d.ovf   = sh_ovf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      flg_q <= '0;
    end else begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign result_o = res_q;
  assign carry_o  = flg_q.carry;
  assign ext_o    = flg_q.ext;
  assign zero_o   = flg_q.zero;
  assign neg_o    = flg_q.neg;
  assign ovf_o    = flg_q.ovf;

endmodule

// File: rtl/shrot_checker.sv
module shrot_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_i,
  input logic [1:0]        size_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [DATA_W-1:0] operand_i,
  input logic              ext_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              ext_o,
  input logic              zero_o,
  input logic              neg_o,
  input logic              ovf_o
);
  localparam int BYTE_W = DATA_W / 4;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (result_o == '0 && !carry_o && !ext_o && !zero_o && !neg_o && !ovf_o)); // R10

  AST_BYTE_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
    (size_i == 2'd0) |=> (result_o[DATA_W-1:BYTE_W] == $past(operand_i[DATA_W-1:BYTE_W]))); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (op_i != 3'd0) |=> !ovf_o); // R3

  AST_ROT_KEEP_EXT: assert property (@(posedge clk) disable iff (rst)
    (op_i[2:1] == 2'b10) |=> (ext_o == $past(ext_i))); // R4

  AST_XROT_CARRY_EXT: assert property (@(posedge clk) disable iff (rst)
    (op_i[2:1] == 2'b11) |=> (carry_o == ext_o)); // R5

  AST_ZERO_COUNT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (count_i == '0) |=> (result_o == $past(operand_i) && ext_o == $past(ext_i))); // R6

  AST_SHIFT_CARRY_EXT: assert property (@(posedge clk) disable iff (rst)
    (!op_i[2] && count_i != '0) |=> (carry_o == ext_o)); // R7

  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (rst)
    zero_o |-> !neg_o); // R9

endmodule

bind shrot_unit shrot_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_i      (op_i),
  .size_i    (size_i),
  .count_i   (count_i),
  .operand_i (operand_i),
  .ext_i     (ext_i),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .ext_o     (ext_o),
  .zero_o    (zero_o),
  .neg_o     (neg_o),
  .ovf_o     (ovf_o)
);

// File: tb/test_shrot_unit.sv
`timescale 1ns/100ps
module test_shrot_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic [5:0]  cnt = '0;
  logic [31:0] opnd = '0;
  logic        ext = 1'b0;
  logic [31:0] result_o;
  logic        carry_o, ext_o, zero_o, neg_o, ovf_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  shrot_unit i_shrot_unit (
    .clk(clk), .rst(rst), .op_i(op), .size_i(size), .count_i(cnt),
    .operand_i(opnd), .ext_i(ext), .result_o(result_o), .carry_o(carry_o),
    .ext_o(ext_o), .zero_o(zero_o), .neg_o(neg_o), .ovf_o(ovf_o)
  );

  // step-by-step reference: one bit moves per count step
  task automatic model(input logic [2:0] o, input logic [1:0] s, input logic [5:0] c,
                       input logic [31:0] a, input logic x,
                       output logic [31:0] r, output logic co, output logic xo,
                       output logic zo, output logic no, output logic vo);
    int n;
    logic [31:0] m, b;
    logic out, top;
    n = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    b = a & m; co = 1'b0; xo = x; vo = 1'b0; out = 1'b0;
    for (int i = 0; i < int'(c); i++) begin
      top = b[n-1];
      case (o)
        3'd0, 3'd2: begin out = b[n-1]; b = (b << 1) & m; end
        3'd1: begin out = b[0]; b = (b >> 1) | ({31'd0, b[n-1]} << (n-1)); end
        3'd3: begin out = b[0]; b = b >> 1; end
        3'd4: begin out = b[n-1]; b = ((b << 1) | {31'd0, out}) & m; end
        3'd5: begin out = b[0]; b = (b >> 1) | ({31'd0, out} << (n-1)); end
        3'd6: begin out = b[n-1]; b = ((b << 1) | {31'd0, xo}) & m; end
        default: begin out = b[0]; b = (b >> 1) | ({31'd0, xo} << (n-1)); end
      endcase
      co = out;
      if (o != 3'd4 && o != 3'd5) xo = out;
      if (o == 3'd0 && b[n-1] != top) vo = 1'b1;
    end
    if (o >= 3'd6) co = xo;
    r  = (a & ~m) | b;
    zo = (b == 32'd0);
    no = b[n-1];
  endtask

  task automatic run_op(input string tag, input logic [2:0] o, input logic [1:0] s,
                        input logic [5:0] c, input logic [31:0] a, input logic x);
    logic [31:0] er;
    logic ec, ex, ez, en, ev;
    @(negedge clk);
    op = o; size = s; cnt = c; opnd = a; ext = x;
    @(posedge clk);
    @(negedge clk);
    model(o, s, c, a, x, er, ec, ex, ez, en, ev);
    checks++;
    if ({result_o, carry_o, ext_o, zero_o, neg_o, ovf_o} != {er, ec, ex, ez, en, ev}) begin
      fails++;
      $display("FAIL %s op=%0d sz=%0d cnt=%0d a=%h x=%b: got r=%h c%b x%b z%b n%b v%b exp r=%h c%b x%b z%b n%b v%b",
               tag, o, s, c, a, x, result_o, carry_o, ext_o, zero_o, neg_o, ovf_o,
               er, ec, ex, ez, en, ev);
    end
  endtask

  task automatic run_lit(input string tag, input logic [2:0] o, input logic [1:0] s,
                         input logic [5:0] c, input logic [31:0] a, input logic x,
                         input logic [31:0] er, input logic ec, input logic ev);
    run_op(tag, o, s, c, a, x);
    checks++;
    if (result_o != er || carry_o != ec || ovf_o != ev) begin
      fails++;
      $display("FAIL %s literal: got r=%h c%b v%b exp r=%h c%b v%b",
               tag, result_o, carry_o, ovf_o, er, ec, ev);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; op = 3'd4; size = 2'd2; cnt = 6'd3; opnd = 32'hDEAD_BEEF; ext = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({result_o, carry_o, ext_o, zero_o, neg_o, ovf_o} != 37'd0) begin
      fails++;
      $display("FAIL R10 reset: got r=%h flags=%b%b%b%b%b exp all zero",
               result_o, carry_o, ext_o, zero_o, neg_o, ovf_o);
    end
    rst = 1'b0;
  endtask

  task automatic t_latency;
    logic [31:0] prev;
    run_op("R10", 3'd3, 2'd2, 6'd4, 32'h0000_00F0, 1'b0);
    prev = result_o;
    @(negedge clk);
    op = 3'd2; size = 2'd2; cnt = 6'd8; opnd = 32'h0000_0001; ext = 1'b0;
    #1;
    checks++;
    if (result_o != prev) begin
      fails++;
      $display("FAIL R10 early update: got %h exp %h", result_o, prev);
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (result_o != 32'h0000_0100) begin
      fails++;
      $display("FAIL R10 one-cycle result: got %h exp %h", result_o, 32'h0000_0100);
    end
  endtask

  task automatic t_arith_right;
    run_lit("R1", 3'd1, 2'd0, 6'd3, 32'h1234_5680, 1'b0, 32'h1234_56F0, 1'b0, 1'b0);
    run_lit("R1", 3'd1, 2'd1, 6'd40, 32'h0000_8000, 1'b0, 32'h0000_FFFF, 1'b1, 1'b0);
    run_op("R1", 3'd1, 2'd2, 6'd31, 32'h8000_0001, 1'b0);
    run_op("R1", 3'd1, 2'd0, 6'd8, 32'h0000_007F, 1'b1);
  endtask

  task automatic t_logic;
    run_lit("R2", 3'd3, 2'd1, 6'd1, 32'hFFFF_8001, 1'b0, 32'hFFFF_4000, 1'b1, 1'b0);
    run_lit("R2", 3'd2, 2'd0, 6'd9, 32'h0000_00FF, 1'b1, 32'h0000_0000, 1'b0, 1'b0);
    run_op("R2", 3'd2, 2'd2, 6'd32, 32'h0000_0001, 1'b0);
    run_op("R2", 3'd3, 2'd2, 6'd32, 32'h8000_0000, 1'b0);
  endtask

  task automatic t_arith_left;
    run_lit("R3", 3'd0, 2'd0, 6'd1, 32'h0000_0040, 1'b0, 32'h0000_0080, 1'b0, 1'b1);
    run_lit("R3", 3'd0, 2'd0, 6'd1, 32'h0000_0020, 1'b0, 32'h0000_0040, 1'b0, 1'b0);
    run_lit("R3", 3'd0, 2'd0, 6'd8, 32'h0000_00FF, 1'b0, 32'h0000_0000, 1'b1, 1'b1);
    run_op("R3", 3'd0, 2'd1, 6'd3, 32'h0000_F123, 1'b0);
    run_op("R3", 3'd2, 2'd0, 6'd1, 32'h0000_0040, 1'b0);
  endtask

  task automatic t_rotate;
    run_lit("R4", 3'd4, 2'd0, 6'd1, 32'h0000_0081, 1'b0, 32'h0000_0003, 1'b1, 1'b0);
    run_lit("R4", 3'd4, 2'd0, 6'd8, 32'h0000_0081, 1'b0, 32'h0000_0081, 1'b1, 1'b0);
    run_op("R4", 3'd5, 2'd1, 6'd17, 32'h0000_0001, 1'b1);
    run_op("R4", 3'd5, 2'd2, 6'd63, 32'h8000_0001, 1'b0);
  endtask

  task automatic t_xrotate;
    run_lit("R5", 3'd6, 2'd0, 6'd1, 32'h0000_0080, 1'b0, 32'h0000_0000, 1'b1, 1'b0);
    run_lit("R5", 3'd6, 2'd0, 6'd9, 32'h0000_0080, 1'b0, 32'h0000_0080, 1'b0, 1'b0);
    run_op("R5", 3'd7, 2'd1, 6'd1, 32'h0000_0000, 1'b1);
    run_op("R5", 3'd7, 2'd2, 6'd33, 32'h1234_5678, 1'b1);
  endtask

  task automatic t_zero_count;
    run_lit("R6", 3'd7, 2'd2, 6'd0, 32'hCAFE_F00D, 1'b1, 32'hCAFE_F00D, 1'b1, 1'b0);
    run_lit("R6", 3'd1, 2'd2, 6'd0, 32'hCAFE_F00D, 1'b1, 32'hCAFE_F00D, 1'b0, 1'b0);
    run_op("R6", 3'd4, 2'd0, 6'd0, 32'h0000_0081, 1'b1);
  endtask

  task automatic t_shift_ext;
    run_op("R7", 3'd3, 2'd0, 6'd2, 32'h0000_0002, 1'b0);
    run_op("R7", 3'd2, 2'd1, 6'd2, 32'h0000_4000, 1'b1);
  endtask

  task automatic t_sizes;
    run_lit("R8", 3'd2, 2'd0, 6'd4, 32'hA5A5_A5FF, 1'b0, 32'hA5A5_A5F0, 1'b1, 1'b0);
    run_lit("R8", 3'd2, 2'd1, 6'd4, 32'hA5A5_FFFF, 1'b0, 32'hA5A5_FFF0, 1'b1, 1'b0);
    run_op("R8", 3'd5, 2'd3, 6'd4, 32'h0000_000F, 1'b0);
  endtask

  task automatic t_flags;
    run_op("R9", 3'd3, 2'd0, 6'd8, 32'hFFFF_FFFF, 1'b0);
    run_op("R9", 3'd4, 2'd0, 6'd7, 32'h8000_0001, 1'b0);
    run_op("R9", 3'd3, 2'd1, 6'd1, 32'h8000_0001, 1'b0);
  endtask

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R3";
      3'd1: return "R1";
      3'd2, 3'd3: return "R2";
      3'd4, 3'd5: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic t_sweep;
    logic [31:0] lf;
    int cs[13];
    cs = '{0, 1, 2, 7, 8, 9, 15, 16, 17, 31, 32, 33, 63};
    lf = 32'h1D87_2B41;
    for (int o = 0; o < 8; o++) begin
      for (int s = 0; s < 3; s++) begin
        for (int k = 0; k < 13; k++) begin
          lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
          run_op(tag_of(3'(o)), 3'(o), 2'(s), 6'(cs[k]), lf, lf[5]);
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_arith_right();
    t_logic();
    t_arith_left();
    t_rotate();
    t_xrotate();
    t_zero_count();
    t_shift_ext();
    t_sizes();
    t_flags();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule